// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block drives a single-data-rate SDRAM that has two internal banks and a 16-bit data bus. A host presents one word request at a time through a valid/ready port. Each request carries a bank, a row and a column, a read or write flag, write data and two byte enables. The sequencer turns each request into the SDRAM commands it needs. It keeps one row open per bank. A request to an open row goes straight to the column command. A request to a different row first closes the row that is open, then activates the new one. A request to a closed bank activates it.

The command spacing is set by parameters counted in clocks: activate-to-column, precharge-to-activate, refresh recovery and mode-load recovery. A single down-counter enforces all of them. A free-running interval counter computes the refresh cadence from the clock rate, the refresh period and the row count. Whenever a refresh is due it comes before host traffic. Read data is captured exactly the programmed read latency after the device samples the read, and is returned on a one-cycle strobe. After reset the block runs a power-up sequence before it accepts any request.

The states of the state machine are as follows:
- ST_POWERUP waits out the power-up delay, then issues precharge-all and moves to ST_INIT_REF_A.
- ST_INIT_REF_A refreshes and moves to ST_INIT_REF_B.
- ST_INIT_REF_B refreshes and moves to ST_INIT_MODE.
- ST_INIT_MODE loads the mode word and moves to ST_IDLE.
- In ST_IDLE the block serves requests: a row hit stays in ST_IDLE; a row miss precharges the bank and moves to ST_ROW_OPEN; a closed bank is activated in place and the state stays ST_IDLE.
- A due refresh with rows open precharges all banks and moves to ST_REFRESH. A due refresh with all rows closed refreshes in place.
- ST_ROW_OPEN activates the new row and returns to ST_IDLE.
- ST_REFRESH refreshes and returns to ST_IDLE.

Top module: `sdram_seq`

## Requirements
- R1: After reset the command pins hold no-op for at least INIT_WAIT cycles. The power-up commands then follow in this order: precharge with address bit 10 high, auto-refresh, auto-refresh, then mode load. The mode word has the read latency in address bits 6:4 and zeros in bits 3:0 (single-word burst, sequential). No column command appears before the mode load.
- R2: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows: no-op 0111, activate 0011, read 0101, write 0100, precharge 0010, auto-refresh 0001, mode load 0000. No other pattern is ever driven.
- R3: A read or write follows the last activate by at least T_RCD clocks.
- R4: An activate follows the last precharge by at least T_RP clocks. Any command follows the last auto-refresh by at least T_RFC clocks.
- R5: For every read, rd_valid pulses for one cycle. It pulses CAS_LAT+1 clocks after the read command appears on the pins, and rd_data is the data the device drove CAS_LAT clocks after it sampled the read. Results come back in request order.
- R6: On a write, sd_dqm is the inverse of req_be: bit 1 masks the upper byte and bit 0 the lower. Only the enabled bytes change in the device.
- R7: Requests to a row that is already open are accepted on consecutive cycles, with one column command per cycle and no idle cycles in between.
- R8: A request to a bank whose open row differs from the requested row causes a precharge of that bank (address bit 10 low) before the activate. An activate is never issued to a bank that is already open.
- R9: Successive auto-refresh commands are no more than the refresh interval (CLK_KHZ*REF_MS/REF_ROWS cycles) plus the precharge, activate and refresh recovery gaps apart, even under continuous host traffic.
- R10: Every auto-refresh is issued with both banks closed. If a row is open when a refresh falls due, a precharge with address bit 10 high is issued first.
- R11: The bank is carried on sd_addr bit 11 for activate, read, write and single-bank precharge. The host address is {bank, row[10:0], column[7:0]}.
- R12: sd_dq_oe is high only in cycles that carry a write command.
- R13: sd_cke is held high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every command is sampled by the device on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present; fields held until accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | {bank, row, column} |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables (bit 1 upper byte) |
| req_ready | output | 1 | Request accepted on this clock edge |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 16 | Read data |
| sd_cke | output | 1 | Clock enable, always high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 12 | Row/column/mode address; bit 11 selects the bank |
| sd_dqm | output | 2 | Byte masks (bit 1 upper) |
| sd_dq_out | output | 16 | Write data to the device |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_in | input | 16 | Data from the device |

## Verification
A refresh can fall due in the same cycle that a host request is waiting, and often while a row is still open from earlier traffic. The bench keeps the request port busy for a long run of mixed reads and writes over a few rows in both banks, so refresh deadlines keep landing on pending requests and on open rows. The judgement is made in three ways. A device model flags any refresh issued with a bank still open. The gap between refreshes is checked against the interval bound. Every read returned after a refresh must still match the scoreboard.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // Pin pattern {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010,
        CMD_REF = 4'b0001,
        CMD_MRS = 4'b0000
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_INIT_REF_A,
        ST_INIT_REF_B,
        ST_INIT_MODE,
        ST_IDLE,
        ST_ROW_OPEN,
        ST_REFRESH
    } seq_state_e;

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
    parameter int W         = 8,
    parameter int RESET_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= W'(RESET_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int INTERVAL = 781
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic pending
);
    localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= CW'(INTERVAL - 1);
            pending <= 1'b0;
        end else begin
            cnt <= tick ? CW'(INTERVAL - 1) : cnt - 1'b1;
            if (tick)
                pending <= 1'b1;
            else if (clear)
                pending <= 1'b0;
        end
    end
endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
    parameter int CAS_LAT = 2,
    parameter int DW      = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_issue,
    input  logic [DW-1:0] dq_in,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    // Stage k is set k edges after the read reaches the pins.
    logic [CAS_LAT:0] stage;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            stage    <= {stage[CAS_LAT-1:0], rd_issue};
            rd_valid <= stage[CAS_LAT];
            if (stage[CAS_LAT])
                rd_data <= dq_in;
        end
    end
endmodule

// File: rtl/sdram_seq.sv
module sdram_seq #(
    parameter int ROW_W     = 11,
    parameter int COL_W     = 8,
    parameter int BANKS     = 2,
    parameter int DQ_W      = 16,
    parameter int CAS_LAT   = 2,
    parameter int CLK_KHZ   = 50000,
    parameter int REF_MS    = 64,
    parameter int REF_ROWS  = 4096,
    parameter int INIT_WAIT = 10000,
    parameter int T_RCD     = 2,
    parameter int T_RP      = 2,
    parameter int T_RFC     = 4,
    parameter int T_MRD     = 2,
    localparam int BANK_W   = $clog2(BANKS),
    localparam int BE_W     = DQ_W / 8,
    localparam int ADDR_W   = BANK_W + ROW_W + COL_W,
    localparam int SA_W     = BANK_W + ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DQ_W-1:0]   req_wdata,
    input  logic [BE_W-1:0]   req_be,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DQ_W-1:0]   rd_data,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [SA_W-1:0]   sd_addr,
    output logic [BE_W-1:0]   sd_dqm,
    output logic [DQ_W-1:0]   sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DQ_W-1:0]   sd_dq_in
);
    import sdram_seq_pkg::*;

    localparam int AP_BIT   = 10;
    localparam int REF_INT  = CLK_KHZ * REF_MS / REF_ROWS;
    localparam int M1       = (T_RFC > T_RP) ? T_RFC : T_RP;
    localparam int M2       = (M1 > T_RCD) ? M1 : T_RCD;
    localparam int M3       = (M2 > T_MRD) ? M2 : T_MRD;
    localparam int GAP_MAX  = (M3 > INIT_WAIT) ? M3 : INIT_WAIT;
    localparam int GAP_W    = $clog2(GAP_MAX + 1);
    localparam logic [SA_W-1:0] MODE_WORD = SA_W'(CAS_LAT << 4);

    seq_state_e state, nxt_state;
    sd_cmd_e    cmd_q, nxt_cmd;
    logic [SA_W-1:0]  nxt_addr;
    logic             gap_load, gap_zero, ref_pending, ref_clr;
    logic [GAP_W-1:0] gap_val;

    logic [BANKS-1:0]            open_vld;
    logic [BANKS-1:0][ROW_W-1:0] open_row;

    logic [BANK_W-1:0] req_bank;
    logic [ROW_W-1:0]  req_row;
    logic [COL_W-1:0]  req_col;
    logic              row_hit;

    assign req_bank = req_addr[ADDR_W-1 -: BANK_W];
    assign req_row  = req_addr[COL_W +: ROW_W];
    assign req_col  = req_addr[COL_W-1:0];
    assign row_hit  = open_vld[req_bank] && (open_row[req_bank] == req_row);

    sdram_gap_timer #(.W(GAP_W), .RESET_VAL(INIT_WAIT)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(gap_val), .expired(gap_zero)
    );

    sdram_refresh_timer #(.INTERVAL(REF_INT)) u_ref (
        .clk(clk), .rst_n(rst_n), .clear(ref_clr), .pending(ref_pending)
    );

    sdram_rd_capture #(.CAS_LAT(CAS_LAT), .DW(DQ_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .rd_issue(nxt_cmd == CMD_RD),
        .dq_in(sd_dq_in), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // Next state and the command for the coming cycle
    always_comb begin
        nxt_state = state;
        nxt_cmd   = CMD_NOP;
        nxt_addr  = '0;
        gap_load  = 1'b0;
        gap_val   = '0;
        ref_clr   = 1'b0;
        req_ready = 1'b0;
        unique case (state)
            ST_POWERUP: if (gap_zero) begin
                nxt_cmd          = CMD_PRE;
                nxt_addr[AP_BIT] = 1'b1;
                gap_load         = 1'b1;
                gap_val          = GAP_W'(T_RP - 1);
                nxt_state        = ST_INIT_REF_A;
            end
            ST_INIT_REF_A: if (gap_zero) begin
                nxt_cmd   = CMD_REF;
                gap_load  = 1'b1;
                gap_val   = GAP_W'(T_RFC - 1);
                nxt_state = ST_INIT_REF_B;
            end
            ST_INIT_REF_B: if (gap_zero) begin
                nxt_cmd   = CMD_REF;
                gap_load  = 1'b1;
                gap_val   = GAP_W'(T_RFC - 1);
                nxt_state = ST_INIT_MODE;
            end
            ST_INIT_MODE: if (gap_zero) begin
                nxt_cmd   = CMD_MRS;
                nxt_addr  = MODE_WORD;
                gap_load  = 1'b1;
                gap_val   = GAP_W'(T_MRD - 1);
                nxt_state = ST_IDLE;
            end
            ST_IDLE: if (gap_zero) begin
                if (ref_pending) begin
                    gap_load = 1'b1;
                    if (|open_vld) begin
                        nxt_cmd          = CMD_PRE;
                        nxt_addr[AP_BIT] = 1'b1;
                        gap_val          = GAP_W'(T_RP - 1);
                        nxt_state        = ST_REFRESH;
                    end else begin
                        nxt_cmd = CMD_REF;
                        gap_val = GAP_W'(T_RFC - 1);
                        ref_clr = 1'b1;
                    end
                end else if (req_valid) begin
                    if (row_hit) begin
                        nxt_cmd                       = req_write ? CMD_WR : CMD_RD;
                        nxt_addr[SA_W-1 -: BANK_W]    = req_bank;
                        nxt_addr[COL_W-1:0]           = req_col;
                        req_ready                     = 1'b1;
                    end else if (open_vld[req_bank]) begin
                        nxt_cmd                       = CMD_PRE;
                        nxt_addr[SA_W-1 -: BANK_W]    = req_bank;
                        gap_load                      = 1'b1;
                        gap_val                       = GAP_W'(T_RP - 1);
                        nxt_state                     = ST_ROW_OPEN;
                    end else begin
                        nxt_cmd  = CMD_ACT;
                        nxt_addr = {req_bank, req_row};
                        gap_load = 1'b1;
                        gap_val  = GAP_W'(T_RCD - 1);
                    end
                end
            end
            ST_ROW_OPEN: if (gap_zero) begin
                nxt_cmd   = CMD_ACT;
                nxt_addr  = {req_bank, req_row};
                gap_load  = 1'b1;
                gap_val   = GAP_W'(T_RCD - 1);
                nxt_state = ST_IDLE;
            end
            ST_REFRESH: if (gap_zero) begin
                nxt_cmd   = CMD_REF;
                gap_load  = 1'b1;
                gap_val   = GAP_W'(T_RFC - 1);
                ref_clr   = 1'b1;
                nxt_state = ST_IDLE;
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_POWERUP;
        else
            state <= nxt_state;
    end

    // Registered pin outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= CMD_NOP;
            sd_addr   <= '0;
            sd_dqm    <= '0;
            sd_dq_out <= '0;
            sd_dq_oe  <= 1'b0;
        end else begin
            cmd_q     <= nxt_cmd;
            sd_addr   <= nxt_addr;
            sd_dq_oe  <= (nxt_cmd == CMD_WR);
            sd_dqm    <= (nxt_cmd == CMD_WR) ? ~req_be : '0;
            if (nxt_cmd == CMD_WR)
                sd_dq_out <= req_wdata;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
    assign sd_cke = 1'b1;

    // Open-row bookkeeping, one slice per bank
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic sel;
        assign sel = (nxt_addr[SA_W-1 -: BANK_W] == BANK_W'(b));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_vld[b] <= 1'b0;
                open_row[b] <= '0;
            end else if (nxt_cmd == CMD_ACT && sel) begin
                open_vld[b] <= 1'b1;
                open_row[b] <= nxt_addr[ROW_W-1:0];
            end else if (nxt_cmd == CMD_PRE && (sel || nxt_addr[AP_BIT])) begin
                open_vld[b] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk #(
    parameter int T_RCD   = 2,
    parameter int T_RP    = 2,
    parameter int T_RFC   = 4,
    parameter int CAS_LAT = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] cmd,
    input logic       dq_oe,
    input logic       rd_valid
);
    import sdram_seq_pkg::*;

    logic [15:0] since_act, since_pre, since_ref;
    logic        mode_seen;
    logic        is_col;

    assign is_col = (cmd == CMD_RD) || (cmd == CMD_WR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act <= 16'hFFFF;
            since_pre <= 16'hFFFF;
            since_ref <= 16'hFFFF;
            mode_seen <= 1'b0;
        end else begin
            since_act <= (cmd == CMD_ACT) ? 16'd1 : (since_act == 16'hFFFF ? since_act : since_act + 1'b1);
            since_pre <= (cmd == CMD_PRE) ? 16'd1 : (since_pre == 16'hFFFF ? since_pre : since_pre + 1'b1);
            since_ref <= (cmd == CMD_REF) ? 16'd1 : (since_ref == 16'hFFFF ? since_ref : since_ref + 1'b1);
            if (cmd == CMD_MRS)
                mode_seen <= 1'b1;
        end
    end

    // R2
    legal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NOP) || (cmd == CMD_ACT) || (cmd == CMD_RD) || (cmd == CMD_WR) ||
        (cmd == CMD_PRE) || (cmd == CMD_REF) || (cmd == CMD_MRS));

    // R1
    init_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> mode_seen);

    // R3
    act_to_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> (since_act >= 16'(T_RCD)));

    // R4
    pre_to_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |-> (since_pre >= 16'(T_RP)));

    // R4
    ref_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |-> (since_ref >= 16'(T_RFC)));

    // R12
    dq_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (cmd == CMD_WR));

    // R5
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cmd == CMD_RD, CAS_LAT + 1));
endmodule

bind sdram_seq sdram_seq_chk #(
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .CAS_LAT(CAS_LAT)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cmd({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
    .dq_oe(sd_dq_oe), .rd_valid(rd_valid)
);

// File: tb/tb_sdram_seq.sv
module tb_sdram_seq;
    import sdram_seq_pkg::*;

    localparam int CL    = 3;
    localparam int IW    = 50;
    localparam int RCD   = 2;
    localparam int RP    = 2;
    localparam int RFC   = 6;
    localparam int MRD   = 2;
    localparam int KHZ   = 50000;
    localparam int MS    = 64;
    localparam int ROWS  = 4096;
    localparam int REF_INTERVAL = KHZ * MS / ROWS;
    localparam int REF_BOUND    = REF_INTERVAL + 2 * RP + RCD + RFC + 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rd_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [15:0] rd_data, sd_dq_out, sd_dq_in;
    logic [11:0] sd_addr;
    logic [1:0]  sd_dqm;

    sdram_seq #(
        .CAS_LAT(CL), .CLK_KHZ(KHZ), .REF_MS(MS), .REF_ROWS(ROWS), .INIT_WAIT(IW),
        .T_RCD(RCD), .T_RP(RP), .T_RFC(RFC), .T_MRD(MRD)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr),
        .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    always #10 clk = ~clk;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // ---------------- device model and command monitor ----------------
    logic [15:0] mmem [int];
    logic [10:0] mrow [2];
    bit          mopen [2];
    logic [15:0] mpipe [4];
    int  since_act = 1000, since_pre = 1000, since_ref = 1000;
    int  nops = 0, init_step = 0, ref_count = 0, last_ref = -1;
    bit  init_done = 0;

    assign sd_dq_in = mpipe[CL];

    initial for (int i = 0; i < 4; i++) mpipe[i] = 16'hDEAD;

    always @(negedge clk) if (rst_n) begin
        logic [3:0] c;
        int b, key;
        logic [15:0] w;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        b = int'(sd_addr[11]);
        for (int i = 3; i > 0; i--) mpipe[i] = mpipe[i-1];
        mpipe[0] = 16'hDEAD;
        since_act++; since_pre++; since_ref++;
        if (c == CMD_NOP) begin
            if (init_step == 0) nops++;
        end else begin
            chk(sd_cke == 1'b1, "R13 cke", 32'(sd_cke), 32'd1);
            chk(since_ref >= RFC, "R4 refresh recovery", since_ref, RFC);
            chk(sd_dq_oe == (c == CMD_WR), "R12 bus drive", 32'(sd_dq_oe), 32'(c == CMD_WR));
            if (!init_done) begin
                case (init_step)
                    0: begin
                        chk(c == CMD_PRE && sd_addr[10], "R1 first cmd precharge-all", {c, sd_addr}, {CMD_PRE, 12'h400});
                        chk(nops >= IW, "R1 power-up wait", nops, IW);
                    end
                    1, 2: chk(c == CMD_REF, "R1 init refresh", c, CMD_REF);
                    default: begin
                        chk(c == CMD_MRS && sd_addr == 12'(CL << 4), "R1 mode word", {c, sd_addr}, {CMD_MRS, 12'(CL << 4)});
                        init_done = 1;
                    end
                endcase
                init_step++;
                if (c == CMD_PRE) begin mopen[0] = 0; mopen[1] = 0; since_pre = 0; end
                if (c == CMD_REF) since_ref = 0;
            end else begin
                case (c)
                    CMD_ACT: begin
                        chk(since_pre >= RP, "R4 precharge to activate", since_pre, RP);
                        chk(!mopen[b], "R8 activate on open bank", 32'(mopen[b]), 32'd0);
                        mopen[b] = 1; mrow[b] = sd_addr[10:0]; since_act = 0;
                    end
                    CMD_RD, CMD_WR: begin
                        chk(since_act >= RCD, "R3 activate to column", since_act, RCD);
                        chk(mopen[b], "R11 column to open bank", 32'(mopen[b]), 32'd1);
                        key = {b, mrow[b], sd_addr[7:0]};
                        w = mmem.exists(key) ? mmem[key] : 16'h0000;
                        if (c == CMD_RD) mpipe[0] = w;
                        else begin
                            if (!sd_dqm[0]) w[7:0]  = sd_dq_out[7:0];
                            if (!sd_dqm[1]) w[15:8] = sd_dq_out[15:8];
                            mmem[key] = w;
                        end
                    end
                    CMD_PRE: begin
                        if (sd_addr[10]) begin mopen[0] = 0; mopen[1] = 0; end
                        else mopen[b] = 0;
                        since_pre = 0;
                    end
                    CMD_REF: begin
                        chk(!mopen[0] && !mopen[1], "R10 refresh with open row", {mopen[1], mopen[0]}, 2'b00);
                        if (last_ref >= 0)
                            chk(cyc - last_ref <= REF_BOUND, "R9 refresh spacing", cyc - last_ref, REF_BOUND);
                        last_ref = cyc; ref_count++; since_ref = 0;
                    end
                    default: chk(1'b0, "R2 unexpected command", c, CMD_NOP);
                endcase
            end
        end
    end

    // ---------------- scoreboard ----------------
    logic [15:0] exp_q [$];
    logic [15:0] exp_mem [int];

    always @(negedge clk) if (rst_n && rd_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected read data", rd_data, 16'h0);
        else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            chk(rd_data === e, "R5 read data", rd_data, e);
        end
    end

    int acc_cyc;

    task automatic send(bit w, logic [19:0] a, logic [15:0] d, logic [1:0] be);
        logic [15:0] old;
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        acc_cyc = cyc;
        old = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 16'h0000;
        if (w) begin
            if (be[0]) old[7:0]  = d[7:0];
            if (be[1]) old[15:8] = d[15:8];
            exp_mem[int'(a)] = old;
        end else exp_q.push_back(old);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        req_valid = 0;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [19:0] mk(int bank, int row, int col);
        return {1'(bank), 11'(row), 8'(col)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        finish_run();
    end

    initial begin
        int first, refs0, start_c;
        repeat (4) @(negedge clk);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_NOP && !sd_dq_oe && !rd_valid && !req_ready,
            "R1 reset state", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe, rd_valid, req_ready},
            {CMD_NOP, 3'b000});
        rst_n = 1;
        // R1: requests are held off until the power-up sequence ends
        req_valid = 1; req_write = 0; req_addr = mk(0, 1, 1);
        repeat (IW) begin
            @(negedge clk); #1;
            if (req_ready) chk(1'b0, "R1 accepted during power-up", 1, 0);
        end
        req_valid = 0;
        wait (init_done);
        idle(5);
        chk(init_step == 4, "R1 init sequence length", init_step, 4);

        // R11: same row and column in both banks keep separate data
        send(1, mk(0, 5, 3), 16'h1111, 2'b11);
        send(1, mk(1, 5, 3), 16'h2222, 2'b11);
        send(0, mk(0, 5, 3), 0, 0);
        send(0, mk(1, 5, 3), 0, 0);
        // R6: byte masks
        send(1, mk(0, 5, 4), 16'hABCD, 2'b11);
        send(1, mk(0, 5, 4), 16'h0012, 2'b01);
        send(0, mk(0, 5, 4), 0, 0);
        send(1, mk(0, 5, 4), 16'h3400, 2'b10);
        send(1, mk(0, 5, 4), 16'hFFFF, 2'b00);
        send(0, mk(0, 5, 4), 0, 0);
        // R8: row misses in bank 0
        send(1, mk(0, 9, 3), 16'h5555, 2'b11);
        send(0, mk(0, 5, 3), 0, 0);
        send(0, mk(0, 9, 3), 0, 0);
        idle(10);

        // R7: back-to-back row hits, retried if a refresh intervenes
        for (int i = 0; i < 4; i++) send(1, mk(1, 7, i), 16'h7000 + 16'(i), 2'b11);
        for (int t = 0; t < 3; t++) begin
            send(0, mk(1, 7, 0), 0, 0);
            refs0 = ref_count;
            send(0, mk(1, 7, 0), 0, 0); first = acc_cyc;
            for (int i = 1; i < 4; i++) send(0, mk(1, 7, i), 0, 0);
            if (ref_count == refs0 || t == 2) begin
                chk(acc_cyc - first == 3, "R7 back-to-back hits", acc_cyc - first, 3);
                break;
            end
        end
        idle(10);

        // R9 R10: dense mixed traffic across refresh deadlines
        start_c = cyc; refs0 = ref_count;
        for (int i = 0; i < 1500; i++) begin
            int bk, rw, cl;
            bk = int'($urandom_range(1)); rw = int'($urandom_range(3)); cl = int'($urandom_range(7));
            if ($urandom_range(1) == 1)
                send(1, mk(bk, rw, cl), 16'($urandom), 2'($urandom_range(3)));
            else
                send(0, mk(bk, rw, cl), 0, 0);
            if ($urandom_range(15) == 0) idle(1);
        end
        idle(30);
        chk(ref_count - refs0 >= (cyc - start_c) / REF_BOUND, "R9 refresh count", ref_count - refs0,
            (cyc - start_c) / REF_BOUND);
        chk(exp_q.size() == 0, "R5 all reads returned", exp_q.size(), 0);
        chk(sd_cke == 1'b1, "R13 cke at end", 32'(sd_cke), 32'd1);
        finish_run();
    end
endmodule